// File: doc/BRIEF.md
# Two-Point Calibrated Code-to-Millivolt Converter

This block turns a 12-bit raw converter code into a millivolt reading. It holds two straight calibration lines. The big line passes through 4200 mV and 3600 mV, and the small line passes through 1000 mV and 100 mV. The code coordinate of each point is trimmed at run time from one byte of a 16-bit trim word, which is added to a nominal code given as a parameter.

Once the line value is found, the block ends the job in one of two ways. One fixed channel returns the big-line value as it is, and another returns the small-line value as it is. Every other channel takes the small-line value and multiplies it by a divider ratio that arrives on an input, with rounding to the nearest integer.

The block handles one job at a time. It raises `ready` while idle, takes a job when `in_valid` is high, and pulses `out_valid` once with the result. Both divisions go through a single iterative divider that works one bit per cycle.

Top module: `adc_volt_conv`

## Requirements
- R1: Each code point is (trim byte + nominal code − 128) × 4, computed signed. The low byte of the trim word (bits 7:0) gives the 4200/1000 mV point c0, and the high byte (bits 15:8) gives the 3600/100 mV point c1. `trim_big` feeds the big line and `trim_small` feeds the small line.
- R2: The line value is (v0 − v1) × (code − c1) / (c0 − c1) + v1. The division truncates toward zero.
- R3: A negative line value is replaced by 0.
- R4: Channel 5 outputs the big-line value (4200/3600 mV) without any ratio step.
- R5: Channel 1 outputs the small-line value (1000/100 mV) without any ratio step.
- R6: Every other channel outputs (line × den + num/2) / num, using the small line. `in_ratio` carries num in bits 31:16 and den in bits 15:0, and num/2 truncates.
- R7: If c0 equals c1 on the selected line, the block outputs 0 with `out_err` = 1.
- R8: A ratio channel with num = 0 outputs 0 with `out_err` = 1. On channels 1 and 5 the ratio is ignored and `out_err` = 0.
- R9: A job is taken only while `ready` = 1. `ready` drops on the cycle after a job is taken. `in_valid` is ignored while `ready` = 0, and the result still belongs to the job that was taken.
- R10: After reset `ready` = 1 and `out_valid` = 0. `out_valid` lasts exactly one cycle, and on that cycle `ready` is already 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Job request |
| in_code | input | 12 | Raw converter code |
| in_chan | input | 5 | Channel number |
| trim_big | input | 16 | Trim bytes for the big line |
| trim_small | input | 16 | Trim bytes for the small line |
| in_ratio | input | 32 | Divider ratio, num in bits 31:16 and den in bits 15:0 |
| ready | output | 1 | Idle and able to take a job |
| out_valid | output | 1 | One-cycle result strobe |
| out_volt | output | 48 | Result in millivolts |
| out_err | output | 1 | Division by zero avoided; result forced to 0 |

## Verification
A wrong sign flag or a wrong captured trim byte shows up only as a wrong `out_volt`. It appears on the `out_valid` pulse roughly 50 or 100 cycles after the job is taken, so every check compares the value on that pulse. A sequencing fault has a different signature. It shows as `ready` failing to fall after a job is taken, as a second strobe, or as a strobe on a cycle where `ready` is low, and each of these is visible within one cycle.

// File: rtl/adc_conv_pkg.sv
package adc_conv_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PREP,
        ST_DIV1,
        ST_RATIO,
        ST_DIV2
    } conv_state_e;
endpackage

// File: rtl/udiv_iter.sv
module udiv_iter #(
    parameter int W = 48
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start,
    input  logic [W-1:0] dividend,
    input  logic [W-1:0] divisor,
    output logic         done,
    output logic [W-1:0] quotient
);
    localparam int CW = $clog2(W + 1);

    typedef struct packed {
        logic          busy;
        logic          done;
        logic [CW-1:0] cnt;
        logic [W:0]    rem;
        logic [W-1:0]  quo;
        logic [W-1:0]  dvs;
    } div_regs_t;

    div_regs_t q, d;
    logic [W:0] trial;

    always_comb begin
        d      = q;
        d.done = 1'b0;
        trial  = {q.rem[W-1:0], q.quo[W-1]};
        if (start && !q.busy) begin
            d.busy = 1'b1;
            d.cnt  = CW'(W);
            d.rem  = '0;
            d.quo  = dividend;
            d.dvs  = divisor;
        end else if (q.busy) begin
            if (trial >= {1'b0, q.dvs}) begin
                d.rem = trial - {1'b0, q.dvs};
                d.quo = {q.quo[W-2:0], 1'b1};
            end else begin
                d.rem = trial;
                d.quo = {q.quo[W-2:0], 1'b0};
            end
            d.cnt = q.cnt - CW'(1);
            if (q.cnt == CW'(1)) begin
                d.busy = 1'b0;
                d.done = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign done     = q.done;
    assign quotient = q.quo;
endmodule

// File: rtl/adc_volt_conv.sv
module adc_volt_conv
    import adc_conv_pkg::*;
#(
    parameter int CODE_W       = 12,
    parameter int CHAN_W       = 5,
    parameter int DIV_W        = 48,
    parameter int BIG_V0       = 4200,
    parameter int BIG_V1       = 3600,
    parameter int SMALL_V0     = 1000,
    parameter int SMALL_V1     = 100,
    parameter int BIG_NOM0     = 856,
    parameter int BIG_NOM1     = 733,
    parameter int SMALL_NOM0   = 833,
    parameter int SMALL_NOM1   = 80,
    parameter int CH_BIG_DIR   = 5,
    parameter int CH_SMALL_DIR = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [CODE_W-1:0] in_code,
    input  logic [CHAN_W-1:0] in_chan,
    input  logic [15:0]       trim_big,
    input  logic [15:0]       trim_small,
    input  logic [31:0]       in_ratio,
    output logic              ready,
    output logic              out_valid,
    output logic [DIV_W-1:0]  out_volt,
    output logic              out_err
);
    localparam int TRIM_OFS = 128;

    typedef struct packed {
        conv_state_e       st;
        logic [CODE_W-1:0] code;
        logic [CHAN_W-1:0] chan;
        logic [15:0]       trim_b;
        logic [15:0]       trim_s;
        logic [31:0]       ratio;
        logic              neg;
        logic [DIV_W-1:0]  volt;
        logic              ovalid;
        logic              oerr;
        logic [DIV_W-1:0]  ovolt;
    } conv_regs_t;

    conv_regs_t q, d;

    logic                    div_start, div_done;
    logic [DIV_W-1:0]        div_a, div_b, div_q;
    logic                    is_big, is_direct;
    int                      c0, c1, dc, dr, dv, v1;
    logic signed [DIV_W-1:0] dv_x, dr_x, dc_x, prod, qs, sum, v1_x;
    logic [15:0]             r_num, r_den;

    udiv_iter #(.W(DIV_W)) u_div (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (div_start),
        .dividend (div_a),
        .divisor  (div_b),
        .done     (div_done),
        .quotient (div_q)
    );

    always_comb begin
        is_big    = (q.chan == CHAN_W'(CH_BIG_DIR));
        is_direct = is_big || (q.chan == CHAN_W'(CH_SMALL_DIR));
        r_num     = q.ratio[31:16];
        r_den     = q.ratio[15:0];
        if (is_big) begin
            c0 = (int'({24'd0, q.trim_b[7:0]})  + BIG_NOM0 - TRIM_OFS) * 4;
            c1 = (int'({24'd0, q.trim_b[15:8]}) + BIG_NOM1 - TRIM_OFS) * 4;
            dv = BIG_V0 - BIG_V1;
            v1 = BIG_V1;
        end else begin
            c0 = (int'({24'd0, q.trim_s[7:0]})  + SMALL_NOM0 - TRIM_OFS) * 4;
            c1 = (int'({24'd0, q.trim_s[15:8]}) + SMALL_NOM1 - TRIM_OFS) * 4;
            dv = SMALL_V0 - SMALL_V1;
            v1 = SMALL_V1;
        end
        dc   = c0 - c1;
        dr   = int'({{(32-CODE_W){1'b0}}, q.code}) - c1;
        dv_x = DIV_W'(dv);
        dr_x = DIV_W'(dr);
        dc_x = DIV_W'(dc);
        v1_x = DIV_W'(v1);
        prod = dv_x * dr_x;
        qs   = q.neg ? -$signed(div_q) : $signed(div_q);
        sum  = qs + v1_x;
    end

    always_comb begin
        d         = q;
        d.ovalid  = 1'b0;
        div_start = 1'b0;
        div_a     = '0;
        div_b     = '0;
        unique case (q.st)
            ST_IDLE: begin
                if (in_valid) begin
                    d.code   = in_code;
                    d.chan   = in_chan;
                    d.trim_b = trim_big;
                    d.trim_s = trim_small;
                    d.ratio  = in_ratio;
                    d.st     = ST_PREP;
                end
            end
            ST_PREP: begin
                if (dc == 0) begin
                    d.ovalid = 1'b1;
                    d.oerr   = 1'b1;
                    d.ovolt  = '0;
                    d.st     = ST_IDLE;
                end else begin
                    div_start = 1'b1;
                    div_a     = prod[DIV_W-1] ? DIV_W'(-prod) : DIV_W'(prod);
                    div_b     = dc_x[DIV_W-1] ? DIV_W'(-dc_x) : DIV_W'(dc_x);
                    d.neg     = prod[DIV_W-1] ^ dc_x[DIV_W-1];
                    d.st      = ST_DIV1;
                end
            end
            ST_DIV1: begin
                if (div_done) begin
                    d.volt = sum[DIV_W-1] ? '0 : DIV_W'(sum);
                    if (is_direct) begin
                        d.ovalid = 1'b1;
                        d.oerr   = 1'b0;
                        d.ovolt  = sum[DIV_W-1] ? '0 : DIV_W'(sum);
                        d.st     = ST_IDLE;
                    end else if (r_num == 16'd0) begin
                        d.ovalid = 1'b1;
                        d.oerr   = 1'b1;
                        d.ovolt  = '0;
                        d.st     = ST_IDLE;
                    end else begin
                        d.st = ST_RATIO;
                    end
                end
            end
            ST_RATIO: begin
                div_start = 1'b1;
                div_a     = q.volt * DIV_W'(r_den) + DIV_W'(r_num >> 1);
                div_b     = DIV_W'(r_num);
                d.st      = ST_DIV2;
            end
            ST_DIV2: begin
                if (div_done) begin
                    d.ovalid = 1'b1;
                    d.oerr   = 1'b0;
                    d.ovolt  = div_q;
                    d.st     = ST_IDLE;
                end
            end
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q    <= '0;
            q.st <= ST_IDLE;
        end else begin
            q <= d;
        end
    end

    assign ready     = (q.st == ST_IDLE);
    assign out_valid = q.ovalid;
    assign out_volt  = q.ovolt;
    assign out_err   = q.oerr;
endmodule

// File: rtl/adc_volt_conv_chk.sv
module adc_volt_conv_chk #(
    parameter int DIV_W = 48
) (
    input logic             clk,
    input logic             rst_n,
    input logic             in_valid,
    input logic             ready,
    input logic             out_valid,
    input logic [DIV_W-1:0] out_volt,
    input logic             out_err
);
    assert_take_drops_ready_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && ready) |=> !ready);

    assert_err_gives_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_err) |-> (out_volt == '0));

    assert_single_strobe_R10: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |=> !out_valid);

    assert_strobe_when_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> ready);

    assert_busy_until_strobe_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!ready && !out_valid) |=> (!ready || out_valid));
endmodule

bind adc_volt_conv adc_volt_conv_chk #(.DIV_W(DIV_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .ready     (ready),
    .out_valid (out_valid),
    .out_volt  (out_volt),
    .out_err   (out_err)
);

// File: tb/adc_volt_conv_tb.sv
module adc_volt_conv_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [11:0] in_code = '0;
    logic [4:0]  in_chan = '0;
    logic [15:0] trim_big = '0;
    logic [15:0] trim_small = '0;
    logic [31:0] in_ratio = '0;
    logic        ready, out_valid, out_err;
    logic [47:0] out_volt;

    int n_run = 0;
    int n_fail = 0;

    always #4 clk = ~clk;

    adc_volt_conv u_dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_code(in_code),
        .in_chan(in_chan), .trim_big(trim_big), .trim_small(trim_small),
        .in_ratio(in_ratio), .ready(ready), .out_valid(out_valid),
        .out_volt(out_volt), .out_err(out_err)
    );

    // code, chan, trim_big, trim_small, ratio
    localparam int NV = 9;
    localparam logic [80:0] VEC [NV] = '{
        {12'd2000, 5'd1,  16'h8080, 16'h8080, 32'h0000_0000},
        {12'd3200, 5'd5,  16'h8080, 16'h8080, 32'h0000_0000},
        {12'd0,    5'd1,  16'h8080, 16'hFF80, 32'h0000_0000},
        {12'd2000, 5'd7,  16'h8080, 16'h8080, {16'd100, 16'd406}},
        {12'd1500, 5'd14, 16'h8080, 16'h8080, {16'd68, 16'd900}},
        {12'd4095, 5'd0,  16'h8080, 16'h8080, {16'd1, 16'd1}},
        {12'd2900, 5'd5,  16'h3A55, 16'h1234, 32'h0000_0000},
        {12'd777,  5'd1,  16'h0000, 16'h4C9E, 32'h0000_0000},
        {12'd3000, 5'd21, 16'h8080, 16'h7701, {16'd375, 16'd1955}}
    };
    localparam string VTAG [NV] = '{"R5", "R4", "R3", "R6", "R6", "R6", "R1", "R2", "R6"};

    function automatic longint model(input int code, input int chan,
                                     input int tb, input int ts, input int ratio,
                                     output bit err);
        longint c0, c1, v0, v1, t, num, den;
        bit big = (chan == 5);
        int tr = big ? tb : ts;
        err = 0;
        c0 = ((tr & 255) + (big ? 856 : 833) - 128) * 4;
        c1 = (((tr >> 8) & 255) + (big ? 733 : 80) - 128) * 4;
        v0 = big ? 4200 : 1000;
        v1 = big ? 3600 : 100;
        if (c0 == c1) begin err = 1; return 0; end
        t = (v0 - v1) * (code - c1);
        t = t / (c0 - c1);
        t = t + v1;
        if (t < 0) t = 0;
        if (chan == 5 || chan == 1) return t;
        num = (ratio >> 16) & 16'hFFFF;
        den = ratio & 16'hFFFF;
        if (num == 0) begin err = 1; return 0; end
        return (t * den + num / 2) / num;
    endfunction

    task automatic check(input string tag, input longint act, input longint exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic wait_out(output bit got);
        got = 0;
        for (int i = 0; i < 400; i++) begin
            @(negedge clk);
            if (out_valid) begin got = 1; return; end
        end
    endtask

    task automatic run(input logic [80:0] v, input string tag);
        bit got, e_err;
        longint e;
        e = model(int'(v[80:69]), int'(v[68:64]), int'(v[63:48]),
                  int'(v[47:32]), int'(v[31:0]), e_err);
        @(negedge clk);
        {in_code, in_chan, trim_big, trim_small, in_ratio} = v;
        in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        wait_out(got);
        check({tag, " strobe"}, longint'(got), 1);
        if (got) begin
            check({tag, " value"}, longint'(out_volt), e);
            check({tag, " err"}, longint'(out_err), longint'(e_err));
        end
    endtask

    initial begin
        bit got;
        longint e;
        bit e_err;
        repeat (3) @(negedge clk);
        // R10: reset state
        check("R10 reset ready", longint'(ready), 1);
        check("R10 reset out_valid", longint'(out_valid), 0);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) run(VEC[i], VTAG[i]);

        // R7: c0 == c1 on the big line (low byte 0x10, high byte 0x8B)
        run({12'd1000, 5'd5, 16'h8B10, 16'h8080, 32'h0}, "R7");
        // R8: zero numerator on a ratio channel
        run({12'd2000, 5'd9, 16'h8080, 16'h8080, 32'h0000_0123}, "R8");
        // R8: ratio ignored on channel 5
        run({12'd3300, 5'd5, 16'h8080, 16'h8080, 32'h0000_0123}, "R8 direct");

        // R9: a request while busy is ignored
        e = model(2500, 3, 16'h8080, 16'h8080, {16'd1000, 16'd2586}, e_err);
        @(negedge clk);
        {in_code, in_chan, trim_big, trim_small, in_ratio} =
            {12'd2500, 5'd3, 16'h8080, 16'h8080, 16'd1000, 16'd2586};
        in_valid = 1'b1;
        @(negedge clk);
        check("R9 ready low after take", longint'(ready), 0);
        {in_code, in_chan, trim_big, trim_small, in_ratio} =
            {12'd100, 5'd5, 16'h0000, 16'h0000, 32'h0001_0001};
        repeat (5) @(negedge clk);
        check("R9 ready low while busy", longint'(ready), 0);
        in_valid = 1'b0;
        wait_out(got);
        check("R9 strobe", longint'(got), 1);
        check("R9 first job value", longint'(out_volt), e);
        check("R9 ready on strobe R10", longint'(ready), 1);
        @(negedge clk);
        check("R10 strobe one cycle", longint'(out_valid), 0);

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_run++;
        n_fail++;
        $display("FAIL watchdog expired actual=hung expected=done");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule